// File: doc/BRIEF.md
# Data-Processing Second-Operand Shifter

This block forms the second operand of a data-processing instruction together with the carry that the shifter produces. It reads the instruction word to choose one of three operand forms: a register value shifted by a constant in the instruction, a register value shifted by an amount held in a second register, or an 8-bit constant rotated by an even amount. The caller supplies the two register values and the current carry flag. The block returns the 32-bit operand and the shifter carry.

Each of the four shift kinds has its own rule for a zero amount, an amount of exactly 32 and an amount above 32. The constant-amount form reuses a zero field to encode a full-width shift or a one-place rotate through carry. The result is computed in one combinational path. An optional output register, on by default, holds it for one clock.

Top module: `opnd_shifter`

## Requirements
- R1: `insn[25]`=1 selects the rotated-constant form. `insn[25]`=0 with `insn[4]`=0 selects a constant shift amount taken from `insn[11:7]`. `insn[25]`=0 with `insn[4]`=1 selects a register shift amount taken from `rs_val`. The shift kind is `insn[6:5]`: 00 left logical, 01 right logical, 10 right arithmetic, 11 rotate right.
- R2: A register shift amount uses only `rs_val[7:0]`. Bits above bit 7 have no effect on the operand or on the carry.
- R3: A register shift amount of zero returns `rm_val` unchanged, and the carry equals `carry_in`, for every shift kind.
- R4: A shift amount from 1 to 31 shifts `rm_val` by that amount. The carry is the last bit shifted out: `rm_val[32-n]` for a left shift, and `rm_val[n-1]` for the right shifts and the rotate.
- R5: A register left shift by exactly 32 gives zero with carry `rm_val[0]`. A register right logical shift by exactly 32 gives zero with carry `rm_val[31]`.
- R6: A register left shift or right logical shift by more than 32 gives zero with carry 0.
- R7: A register right arithmetic shift by 32 or more fills every result bit and the carry with `rm_val[31]`.
- R8: A register rotate by a nonzero multiple of 32 returns `rm_val` with carry `rm_val[31]`. Any other rotate amount above 32 acts as a rotate by the amount mod 32.
- R9: The rotated-constant form zero-extends `insn[7:0]` and rotates it right by twice `insn[11:8]`, with carry equal to result bit 31. A rotate field of zero leaves the carry equal to `carry_in`.
- R10: In the constant-amount form, a field of 0 with left shift passes `rm_val` through with carry `carry_in`. A field of 0 with either right shift acts as a shift by 32.
- R11: In the constant-amount form, a field of 0 with rotate gives `{carry_in, rm_val[31:1]}` with carry `rm_val[0]`.
- R12: With REG_OUT=1 (the default), the outputs take the result one clock edge after the inputs are presented. While `rst_n` is low, both outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn | input | 32 | Instruction word |
| rm_val | input | 32 | Value of the operand register |
| rs_val | input | 32 | Value of the shift-amount register |
| carry_in | input | 1 | Current carry flag |
| op_out | output | 32 | Second operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The bench targets the amount boundaries 0, 32, 33 and large values for each shift kind. A design that kept only five amount bits would wrap a shift by 32 or 33 into a small shift, or into no shift at all. A design that treated a zero constant field literally would return `rm_val` for a right shift that should clear it or fill it with the sign, and would miss the rotate through carry. A design that let the upper bits of `rs_val` through, or let `carry_in` leak into a nonzero rotated constant, would show a wrong operand or a wrong carry in the directed vectors.

// File: rtl/opshf_pkg.sv
package opshf_pkg;
  localparam int AMT_W = 8;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } sh_kind_e;

  typedef enum logic [1:0] {
    MD_PASS  = 2'd0,
    MD_RRX   = 2'd1,
    MD_SHIFT = 2'd2
  } sh_mode_e;

  typedef struct packed {
    sh_kind_e         kind;
    sh_mode_e         mode;
    logic [AMT_W-1:0] amt;
  } sh_ctl_t;
endpackage

// File: rtl/opshf_decode.sv
module opshf_decode
  import opshf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [31:0]   insn,
  input  logic [DW-1:0] rm_val,
  input  logic [DW-1:0] rs_val,
  output sh_ctl_t       ctl,
  output logic [DW-1:0] src
);
  localparam int IMM_W = 8;

  logic     is_rot_imm;
  logic     is_reg_amt;
  sh_kind_e kind_f;
  logic [4:0] imm_amt;
  logic [3:0] rot_f;
  logic unused_bits;

  assign is_rot_imm  = insn[25];
  assign is_reg_amt  = ~insn[25] & insn[4];
  assign kind_f      = sh_kind_e'(insn[6:5]);
  assign imm_amt     = insn[11:7];
  assign rot_f       = insn[11:8];
  assign unused_bits = ^{insn[31:26], insn[24:12], insn[3:0], rs_val[DW-1:AMT_W]};

  always_comb begin
    ctl.kind = kind_f;
    ctl.mode = MD_SHIFT;
    ctl.amt  = '0;
    src      = rm_val;
    if (is_rot_imm) begin
      // R9: rotated zero-extended constant
      src      = {{(DW-IMM_W){1'b0}}, insn[IMM_W-1:0]};
      ctl.kind = SH_ROR;
      ctl.amt  = AMT_W'({rot_f, 1'b0});
      if (rot_f == 4'd0) ctl.mode = MD_PASS;
    end else if (is_reg_amt) begin
      // R2, R3: low byte of the amount register only
      ctl.amt = rs_val[AMT_W-1:0];
      if (rs_val[AMT_W-1:0] == '0) ctl.mode = MD_PASS;
    end else begin
      ctl.amt = AMT_W'(imm_amt);
      if (imm_amt == 5'd0) begin
        unique case (kind_f)
          SH_LSL:         ctl.mode = MD_PASS;          // R10
          SH_LSR, SH_ASR: ctl.amt  = AMT_W'(DW);       // R10
          default:        ctl.mode = MD_RRX;           // R11
        endcase
      end
    end
  end
endmodule

// File: rtl/opshf_barrel.sv
module opshf_barrel
  import opshf_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] src,
  input  sh_ctl_t       ctl,
  input  logic          carry_in,
  output logic [DW-1:0] res,
  output logic          cout
);
  localparam int SW = $clog2(DW);

  logic [DW:0]          lsl_w;
  logic [DW:0]          lsr_w;
  logic signed [DW:0]   asr_w;
  logic [2*DW-1:0]      ror_w;
  logic [SW-1:0]        rot;

  // Widened shifts keep the last bit out alongside the result, so
  // amounts of DW and beyond fall out of the arithmetic directly.
  assign lsl_w = {1'b0, src} << ctl.amt;
  assign lsr_w = {src, 1'b0} >> ctl.amt;
  assign asr_w = $signed({src, 1'b0}) >>> ctl.amt;
  assign rot   = ctl.amt[SW-1:0];
  assign ror_w = {src, src} >> rot;

  always_comb begin
    res  = src;
    cout = carry_in;
    unique case (ctl.mode)
      MD_PASS: begin
        res  = src;
        cout = carry_in;
      end
      MD_RRX: begin
        res  = {carry_in, src[DW-1:1]};
        cout = src[0];
      end
      default: begin
        unique case (ctl.kind)
          SH_LSL: {cout, res} = lsl_w;
          SH_LSR: {res, cout} = lsr_w;
          SH_ASR: {res, cout} = asr_w;
          default: begin
            res  = ror_w[DW-1:0];
            cout = ror_w[DW-1];
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/opshf_outreg.sv
module opshf_outreg #(
  parameter int DW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] d_op,
  input  logic          d_c,
  output logic [DW-1:0] q_op,
  output logic          q_c
);
  generate
    if (REG_OUT) begin : g_reg
      logic [DW-1:0] op_nxt, op_q;
      logic          c_nxt, c_q;

      always_comb begin
        op_nxt = d_op;
        c_nxt  = d_c;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          op_q <= '0;
          c_q  <= 1'b0;
        end else begin
          op_q <= op_nxt;
          c_q  <= c_nxt;
        end
      end

      assign q_op = op_q;
      assign q_c  = c_q;
    end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign q_op = d_op;
      assign q_c  = d_c;
    end
  endgenerate
endmodule

// File: rtl/opnd_shifter.sv
module opnd_shifter
  import opshf_pkg::*;
#(
  parameter int DW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   insn,
  input  logic [DW-1:0] rm_val,
  input  logic [DW-1:0] rs_val,
  input  logic          carry_in,
  output logic [DW-1:0] op_out,
  output logic          carry_out
);
  sh_ctl_t       ctl;
  logic [DW-1:0] src;
  logic [DW-1:0] sh_res;
  logic          sh_c;

  opshf_decode #(.DW(DW)) u_dec (
    .insn   (insn),
    .rm_val (rm_val),
    .rs_val (rs_val),
    .ctl    (ctl),
    .src    (src)
  );

  opshf_barrel #(.DW(DW)) u_bsh (
    .src      (src),
    .ctl      (ctl),
    .carry_in (carry_in),
    .res      (sh_res),
    .cout     (sh_c)
  );

  opshf_outreg #(.DW(DW), .REG_OUT(REG_OUT)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .d_op  (sh_res),
    .d_c   (sh_c),
    .q_op  (op_out),
    .q_c   (carry_out)
  );
endmodule

// File: rtl/opnd_shifter_chk.sv
module opnd_shifter_chk #(
  parameter int DW      = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   insn,
  input logic [DW-1:0] rm_val,
  input logic [DW-1:0] rs_val,
  input logic          carry_in,
  input logic [DW-1:0] op_out,
  input logic          carry_out
);
  logic       reg_form;
  logic       rot_form;
  logic [7:0] amt8;
  logic unused_rs;

  assign reg_form  = ~insn[25] & insn[4];
  assign rot_form  = insn[25];
  assign amt8      = rs_val[7:0];
  assign unused_rs = ^rs_val;

  generate
    if (REG_OUT) begin : g_props
      // R3
      a_r3_zero_amount_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_form && amt8 == 8'd0) |=> (op_out == $past(rm_val) && carry_out == $past(carry_in)));
      // R5
      a_r5_lsl_by_32: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_form && insn[6:5] == 2'd0 && amt8 == 8'd32) |=> (op_out == '0 && carry_out == $past(rm_val[0])));
      // R6
      a_r6_logical_over_32: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_form && insn[6] == 1'b0 && amt8 > 8'd32) |=> (op_out == '0 && carry_out == 1'b0));
      // R7
      a_r7_asr_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_form && insn[6:5] == 2'd2 && amt8 >= 8'd32) |=>
          (op_out == {DW{$past(rm_val[DW-1])}} && carry_out == $past(rm_val[DW-1])));
      // R9
      a_r9_rot_zero_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_form && insn[11:8] == 4'd0) |=>
          (op_out == DW'($past(insn[7:0])) && carry_out == $past(carry_in)));
    end
  endgenerate
endmodule

bind opnd_shifter opnd_shifter_chk #(.DW(DW), .REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .insn      (insn),
  .rm_val    (rm_val),
  .rs_val    (rs_val),
  .carry_in  (carry_in),
  .op_out    (op_out),
  .carry_out (carry_out)
);

// File: tb/opnd_shifter_bench.sv
module opnd_shifter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 25;

  typedef struct packed {
    logic [1:0]  form;   // 0 constant amount, 1 register amount, 2 rotated constant
    logic [1:0]  kind;
    logic [4:0]  fld;
    logic [7:0]  imm;
    logic [31:0] rm;
    logic [31:0] rs;
    logic        cin;
    logic [31:0] eo;
    logic        ec;
    logic [7:0]  req;
  } vec_t;

  localparam vec_t VT [NVEC] = '{
    '{2'd0, 2'd0, 5'd4,  8'h00, 32'h12345678, 32'h0,        1'b0, 32'h23456780, 1'b1, 8'd4},  // R4 R1
    '{2'd0, 2'd1, 5'd8,  8'h00, 32'h800000FF, 32'h0,        1'b0, 32'h00800000, 1'b1, 8'd4},  // R4
    '{2'd0, 2'd2, 5'd4,  8'h00, 32'h80000010, 32'h0,        1'b1, 32'hF8000001, 1'b0, 8'd4},  // R4
    '{2'd0, 2'd3, 5'd8,  8'h00, 32'h11223344, 32'h0,        1'b1, 32'h44112233, 1'b0, 8'd4},  // R4
    '{2'd0, 2'd0, 5'd0,  8'h00, 32'hDEADBEEF, 32'h0,        1'b1, 32'hDEADBEEF, 1'b1, 8'd10}, // R10
    '{2'd0, 2'd1, 5'd0,  8'h00, 32'h80000001, 32'h0,        1'b0, 32'h00000000, 1'b1, 8'd10}, // R10
    '{2'd0, 2'd2, 5'd0,  8'h00, 32'h80000000, 32'h0,        1'b0, 32'hFFFFFFFF, 1'b1, 8'd10}, // R10
    '{2'd0, 2'd3, 5'd0,  8'h00, 32'h00000003, 32'h0,        1'b1, 32'h80000001, 1'b1, 8'd11}, // R11
    '{2'd1, 2'd0, 5'd0,  8'h00, 32'h5555AAAA, 32'h0,        1'b1, 32'h5555AAAA, 1'b1, 8'd3},  // R3
    '{2'd1, 2'd1, 5'd0,  8'h00, 32'h00000001, 32'hFFFFFF00, 1'b0, 32'h00000001, 1'b0, 8'd2},  // R2
    '{2'd1, 2'd0, 5'd0,  8'h00, 32'h12345678, 32'h00000104, 1'b0, 32'h23456780, 1'b1, 8'd2},  // R2
    '{2'd1, 2'd1, 5'd0,  8'h00, 32'hF000000F, 32'h00000004, 1'b0, 32'h0F000000, 1'b1, 8'd4},  // R4
    '{2'd1, 2'd0, 5'd0,  8'h00, 32'h00000001, 32'd32,       1'b0, 32'h00000000, 1'b1, 8'd5},  // R5
    '{2'd1, 2'd1, 5'd0,  8'h00, 32'h80000000, 32'd32,       1'b0, 32'h00000000, 1'b1, 8'd5},  // R5
    '{2'd1, 2'd0, 5'd0,  8'h00, 32'hFFFFFFFF, 32'd33,       1'b1, 32'h00000000, 1'b0, 8'd6},  // R6
    '{2'd1, 2'd1, 5'd0,  8'h00, 32'hFFFFFFFF, 32'h000000FF, 1'b1, 32'h00000000, 1'b0, 8'd6},  // R6
    '{2'd1, 2'd2, 5'd0,  8'h00, 32'h80000000, 32'd32,       1'b0, 32'hFFFFFFFF, 1'b1, 8'd7},  // R7
    '{2'd1, 2'd2, 5'd0,  8'h00, 32'h7FFFFFFF, 32'd200,      1'b1, 32'h00000000, 1'b0, 8'd7},  // R7
    '{2'd1, 2'd3, 5'd0,  8'h00, 32'h80000001, 32'd32,       1'b0, 32'h80000001, 1'b1, 8'd8},  // R8
    '{2'd1, 2'd3, 5'd0,  8'h00, 32'h00000001, 32'd64,       1'b1, 32'h00000001, 1'b0, 8'd8},  // R8
    '{2'd1, 2'd3, 5'd0,  8'h00, 32'h000000F1, 32'd36,       1'b1, 32'h1000000F, 1'b0, 8'd8},  // R8
    '{2'd2, 2'd0, 5'd0,  8'hAB, 32'hFFFFFFFF, 32'h0,        1'b1, 32'h000000AB, 1'b1, 8'd9},  // R9
    '{2'd2, 2'd0, 5'd4,  8'hFF, 32'h0,        32'h0,        1'b0, 32'hFF000000, 1'b1, 8'd9},  // R9
    '{2'd2, 2'd0, 5'd1,  8'h01, 32'h0,        32'h0,        1'b1, 32'h40000000, 1'b0, 8'd9},  // R9
    '{2'd2, 2'd0, 5'd15, 8'h03, 32'h0,        32'h0,        1'b1, 32'h0000000C, 1'b0, 8'd9}   // R9
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] insn;
  logic [31:0] rm_val;
  logic [31:0] rs_val;
  logic        carry_in;
  logic [31:0] op_out;
  logic        carry_out;

  int n_chk;
  int n_bad;

  opnd_shifter u_opnd_shifter (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn      (insn),
    .rm_val    (rm_val),
    .rs_val    (rs_val),
    .carry_in  (carry_in),
    .op_out    (op_out),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] mk_insn(logic [1:0] form, logic [1:0] kind,
                                          logic [4:0] fld, logic [7:0] imm);
    logic [31:0] w;
    w = 32'hE000_0000;
    if (form == 2'd2) begin
      w[25]   = 1'b1;
      w[11:8] = fld[3:0];
      w[7:0]  = imm;
    end else if (form == 2'd1) begin
      w[11:8] = 4'd3;
      w[6:5]  = kind;
      w[4]    = 1'b1;
      w[2:0]  = 3'd5;
    end else begin
      w[11:7] = fld;
      w[6:5]  = kind;
      w[2:0]  = 3'd5;
    end
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] eo, logic ec);
    n_chk++;
    if (op_out !== eo || carry_out !== ec) begin
      n_bad++;
      $display("FAIL %s op=%h exp=%h carry=%b exp=%b", tag, op_out, eo, carry_out, ec);
    end
  endtask

  task automatic drive(logic [31:0] w, logic [31:0] rm, logic [31:0] rs, logic c);
    insn     = w;
    rm_val   = rm;
    rs_val   = rs;
    carry_in = c;
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    drive(32'h0200_00FF, 32'hFFFF_FFFF, 32'h0, 1'b1);
    repeat (2) @(negedge clk);
    check("R12 reset", 32'h0, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(mk_insn(VT[i].form, VT[i].kind, VT[i].fld, VT[i].imm), VT[i].rm, VT[i].rs, VT[i].cin);
      @(posedge clk);
      #1;
      check($sformatf("R%0d vec%0d", VT[i].req, i), VT[i].eo, VT[i].ec);
    end

    // R12: new inputs do not reach the outputs before the next edge
    @(negedge clk);
    drive(mk_insn(2'd1, 2'd0, 5'd0, 8'h0), 32'h0000_0001, 32'd1, 1'b0);
    #1;
    check("R12 hold before edge", 32'h0000_000C, 1'b0);
    @(posedge clk);
    #1;
    check("R12 after edge", 32'h0000_0002, 1'b0);

    // R2: same low byte, different upper bits, identical result
    @(negedge clk);
    drive(mk_insn(2'd1, 2'd2, 5'd0, 8'h0), 32'h8000_0000, 32'hABCD_0020, 1'b0);
    @(posedge clk);
    #1;
    check("R2 upper rs bits ignored", 32'hFFFF_FFFF, 1'b1);

    // R1: constant-amount form ignores rs_val entirely
    @(negedge clk);
    drive(mk_insn(2'd0, 2'd1, 5'd1, 8'h0), 32'h0000_0003, 32'h0000_0000, 1'b0);
    @(posedge clk);
    #1;
    check("R1 constant form", 32'h0000_0001, 1'b1);

    // R12: asynchronous reset clears the held result
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R12 async clear", 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule